// File: doc/BRIEF.md
# Shared Data Line Direction Arbiter

This block controls the direction of one open-drain data line that joins a host side and a card side. Both sides rest high through pull-ups. The block samples both levels, synchronizes them and looks for falling edges. The first side that falls becomes master and the other becomes slave. Once a programmable delay has passed, the slave side's pull-down is switched on, so the low travels across. When the master lets go, the slave side gets a short active pull-up pulse to sharpen the rising edge, and after that both sides go back to passive idle. Edges on the slave side are ignored for as long as an owner holds the line.

The pad drivers, resistors and current limiting sit outside the block. It only produces the four enables: pull-down and active pull-up for each side. A line-enable input from the session sequencer holds the card side low and keeps the arbiter idle while the line is out of use. One copy of the block serves each line: the main data line and each auxiliary line. The sum of the synchronizer latency, the edge delay and the pull-up length must stay far below half of a 1 MHz line period.

Top module: `dataline_dir_arbiter`

## Requirements
- R1: While `rst` is high and `line_en` is high, all four enables are 0 (enable vector {host_pd_en, host_pu_en, card_pd_en, card_pu_en} = 4'b0000).
- R2: When the host side falls first, `card_pd_en` rises exactly EDGE_DLY+3 clock edges after the edge that follows the input change: 2 synchronizer stages, 1 decision edge, and EDGE_DLY delay cycles. The host side enables stay 0.
- R3: When the card side falls first, `host_pd_en` rises with the same latency as in R2, and the card side enables stay 0.
- R4: While an owner holds the line, in its delay or in its hold phase, edges on the slave side change no enable and do not move ownership.
- R5: When the master returns high during the hold phase, the slave pull-down stops and the slave pull-up is on for exactly PU_CYC cycles, starting 3 edges after the change. Then all enables return to 0.
- R6: If the master returns high before the edge delay has expired, no pull-down and no pull-up is ever enabled, and the arbiter goes back to idle.
- R7: If both sides fall in the same sample cycle, the host side becomes master, so `card_pd_en` is the enable that rises.
- R8: While `line_en` is low, `card_pd_en` is 1, the other three enables are 0, and the arbiter is idle. A host side fall in this time starts no transfer, even after the line is enabled again. Disabling the line during a transfer ends it with no pull-up pulse.
- R9: While `line_en` is high, at most one of the four enables is active.
- R10: A side that stays low when the arbiter goes back to idle does not take ownership again. Only a new falling edge starts a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_en | input | 1 | Line enable from the session sequencer; low holds the card side low |
| host_lvl | input | 1 | Sampled level of the host side of the line (asynchronous) |
| card_lvl | input | 1 | Sampled level of the card side of the line (asynchronous) |
| host_pd_en | output | 1 | Enable for the host side pull-down |
| host_pu_en | output | 1 | Enable for the host side active pull-up |
| card_pd_en | output | 1 | Enable for the card side pull-down |
| card_pu_en | output | 1 | Enable for the card side active pull-up |

## Verification
The assertions take for granted that a master keeps its line low for more cycles than the synchronizer latency. They also take for granted that level changes are slow enough for each one to be seen as a separate synchronized sample. Without these two conditions the timing and single-owner properties do not describe real line traffic. The stimulus changes the inputs only on falling clock edges, and it holds every level for at least one full cycle. It also lets the synchronizer settle before each new scenario. Slave-side toggling during ownership is driven on purpose, to show that the arbiter disregards it.

// File: rtl/dla_pkg.sv
package dla_pkg;

    // Arbiter phases
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // no owner, both sides passive
        ST_DELAY = 2'd1,   // owner chosen, slave pull-down waiting
        ST_HOLD  = 2'd2,   // slave pull-down copying the low
        ST_PUSH  = 2'd3    // slave active pull-up pulse
    } arb_state_e;

    typedef enum logic {
        OWN_HOST = 1'b0,
        OWN_CARD = 1'b1
    } side_e;

    // Bit positions in the synchronized level vector
    localparam int unsigned HOST_BIT = 1;
    localparam int unsigned CARD_BIT = 0;

    typedef struct packed {
        logic host_pd;
        logic host_pu;
        logic card_pd;
        logic card_pu;
    } drive_t;

    function automatic int unsigned cnt_bits(input int unsigned span);
        return (span < 2) ? 1 : $clog2(span);
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Turn the arbiter phase and owner into pad enables
    function automatic drive_t drive_of(input arb_state_e st,
                                        input side_e owner,
                                        input logic enabled);
        drive_t d;
        d = '0;
        if (!enabled) begin
            d.card_pd = 1'b1;
        end else begin
            unique case (st)
                ST_HOLD: begin
                    if (owner == OWN_HOST) d.card_pd = 1'b1;
                    else                   d.host_pd = 1'b1;
                end
                ST_PUSH: begin
                    if (owner == OWN_HOST) d.card_pu = 1'b1;
                    else                   d.host_pu = 1'b1;
                end
                default: d = '0;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/dla_sync.sv
module dla_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '1;
                    else     chain[s] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '1;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign synced = chain[STAGES-1];

endmodule

// File: rtl/dla_edge.sv
module dla_edge #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= lvl;
    end

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign fall[i] = prev[i] & ~lvl[i];
        end
    endgenerate

endmodule

// File: rtl/dla_timer.sv
module dla_timer #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)      cnt <= '0;
        else if (cnt != '1)  cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/dataline_dir_arbiter.sv
module dataline_dir_arbiter
    import dla_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned EDGE_DLY    = 4,
    parameter int unsigned PU_CYC      = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_en,
    input  logic host_lvl,
    input  logic card_lvl,
    output logic host_pd_en,
    output logic host_pu_en,
    output logic card_pd_en,
    output logic card_pu_en
);
    localparam int unsigned SPAN = max_u(EDGE_DLY, PU_CYC);
    localparam int unsigned CW   = cnt_bits(SPAN);
    localparam logic [CW-1:0] DLY_LAST = CW'(EDGE_DLY - 1);
    localparam logic [CW-1:0] PU_LAST  = CW'(PU_CYC - 1);

    logic [1:0]  lvl_s;
    logic [1:0]  fall;
    logic [CW-1:0] cnt;
    arb_state_e  st, st_nxt;
    side_e       owner, own_nxt;
    logic        master_hi;
    logic        tmr_clr;
    drive_t      drv;

    dla_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    ({host_lvl, card_lvl}),
        .synced (lvl_s)
    );

    dla_edge #(.WIDTH(2)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl_s),
        .fall (fall)
    );

    dla_timer #(.W(CW)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (tmr_clr),
        .cnt (cnt)
    );

    assign master_hi = (owner == OWN_HOST) ? lvl_s[HOST_BIT] : lvl_s[CARD_BIT];

    always_comb begin
        st_nxt  = st;
        own_nxt = owner;
        unique case (st)
            ST_IDLE: begin
                if (fall[HOST_BIT]) begin
                    st_nxt  = ST_DELAY;
                    own_nxt = OWN_HOST;
                end else if (fall[CARD_BIT]) begin
                    st_nxt  = ST_DELAY;
                    own_nxt = OWN_CARD;
                end
            end
            ST_DELAY: begin
                if (master_hi)            st_nxt = ST_IDLE;
                else if (cnt == DLY_LAST) st_nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (master_hi) st_nxt = ST_PUSH;
            end
            ST_PUSH: begin
                if (cnt == PU_LAST) st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
        if (!line_en) st_nxt = ST_IDLE;
    end

    assign tmr_clr = (st_nxt != st);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            owner <= OWN_HOST;
        end else begin
            st    <= st_nxt;
            owner <= own_nxt;
        end
    end

    assign drv        = drive_of(st, owner, line_en);
    assign host_pd_en = drv.host_pd;
    assign host_pu_en = drv.host_pu;
    assign card_pd_en = drv.card_pd;
    assign card_pu_en = drv.card_pu;

    // Assertions next to the logic they guard
    AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (rst)
        line_en |-> $onehot0({host_pd_en, host_pu_en, card_pd_en, card_pu_en})); // R9

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
        !line_en |=> (st == ST_IDLE)); // R8

    AST_HOLD_AFTER_DELAY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD && $past(st) != ST_HOLD) |-> ($past(st) == ST_DELAY && $past(cnt) == DLY_LAST)); // R2

    AST_PUSH_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PUSH) |-> (cnt <= PU_LAST)); // R5

    AST_OWNER_KEPT: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && $past(st) != ST_IDLE) |-> $stable(owner)); // R4

    AST_TIE_HOST: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && line_en && fall[HOST_BIT] && fall[CARD_BIT]) |=> (owner == OWN_HOST)); // R7

    AST_EARLY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DELAY && master_hi) |=> (st == ST_IDLE)); // R6

endmodule

// File: tb/test_dataline_dir_arbiter.sv
`timescale 1ns/1ps
module test_dataline_dir_arbiter;

    localparam int DLY  = 4;
    localparam int PU   = 3;
    localparam int LAT  = DLY + 3;  // edges from input change to slave pull-down
    localparam int RLAT = 3;        // edges from release to pull-up pulse

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_en = 1'b1;
    logic host_lvl = 1'b1;
    logic card_lvl = 1'b1;
    logic host_pd_en, host_pu_en, card_pd_en, card_pu_en;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dataline_dir_arbiter #(.SYNC_STAGES(2), .EDGE_DLY(DLY), .PU_CYC(PU)) i_dataline_dir_arbiter (
        .clk(clk), .rst(rst), .line_en(line_en),
        .host_lvl(host_lvl), .card_lvl(card_lvl),
        .host_pd_en(host_pd_en), .host_pu_en(host_pu_en),
        .card_pd_en(card_pd_en), .card_pu_en(card_pu_en)
    );

    // enables vector {host_pd, host_pu, card_pd, card_pu}
    localparam logic [3:0] NONE   = 4'b0000;
    localparam logic [3:0] C_PD   = 4'b0010;
    localparam logic [3:0] C_PU   = 4'b0001;
    localparam logic [3:0] H_PD   = 4'b1000;
    localparam logic [3:0] H_PU   = 4'b0100;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {host_pd_en, host_pu_en, card_pd_en, card_pu_en};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: enables actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic settle();
        tick(6);
    endtask

    task automatic t_reset();
        tick(3);
        chk("R1 reset", NONE);
        rst = 1'b0;
        tick(2);
        chk("R1 after reset idle", NONE);
    endtask

    task automatic t_host_master();
        host_lvl = 1'b0;
        tick(LAT - 1);
        chk("R2 no pull-down before delay", NONE);
        tick(1);
        chk("R2 card pull-down on", C_PD);
        chk("R9 single enable in hold", C_PD);
        host_lvl = 1'b1;
        tick(RLAT - 1);
        chk("R5 still holding", C_PD);
        tick(1);
        chk("R5 card pull-up start", C_PU);
        tick(PU - 1);
        chk("R5 card pull-up last cycle", C_PU);
        tick(1);
        chk("R5 back to idle", NONE);
        settle();
    endtask

    task automatic t_card_master();
        card_lvl = 1'b0;
        tick(LAT - 1);
        chk("R3 no pull-down before delay", NONE);
        tick(1);
        chk("R3 host pull-down on", H_PD);
        card_lvl = 1'b1;
        tick(RLAT);
        chk("R5 host pull-up start", H_PU);
        tick(PU);
        chk("R5 host side idle", NONE);
        settle();
    endtask

    task automatic t_slave_ignored();
        host_lvl = 1'b0;
        tick(3);
        card_lvl = 1'b0;     // slave toggles during the delay phase
        tick(1);
        card_lvl = 1'b1;
        tick(LAT - 4);
        chk("R4 owner kept through delay", C_PD);
        for (int i = 0; i < 4; i++) begin
            card_lvl = ~card_lvl;
            tick(2);
        end
        card_lvl = 1'b0;
        tick(4);
        chk("R4 slave edges ignored in hold", C_PD);
        host_lvl = 1'b1;
        tick(RLAT);
        chk("R4 pull-up goes to card side", C_PU);
        tick(PU + 4);
        chk("R10 held-low slave does not take over", NONE);
        card_lvl = 1'b1;
        settle();
    endtask

    task automatic t_early_release();
        logic [3:0] seen;
        seen = NONE;
        host_lvl = 1'b0;
        tick(1);
        host_lvl = 1'b1;
        for (int i = 0; i < LAT + PU + 4; i++) begin
            tick(1);
            seen = seen | {host_pd_en, host_pu_en, card_pd_en, card_pu_en};
        end
        n_chk++;
        if (seen !== NONE) begin
            n_bad++;
            $display("FAIL R6: enables seen actual=%b expected=%b", seen, NONE);
        end
        settle();
    endtask

    task automatic t_tie();
        host_lvl = 1'b0;
        card_lvl = 1'b0;
        tick(LAT);
        chk("R7 host wins tie", C_PD);
        host_lvl = 1'b1;
        tick(RLAT);
        chk("R7 pull-up on card side", C_PU);
        tick(PU + 4);
        chk("R10 no re-arbitration from held card", NONE);
        card_lvl = 1'b1;
        settle();
    endtask

    task automatic t_disabled();
        line_en  = 1'b0;
        card_lvl = 1'b0;
        tick(1);
        chk("R8 card held low when disabled", C_PD);
        host_lvl = 1'b0;
        tick(LAT + 4);
        chk("R8 host fall ignored when disabled", C_PD);
        line_en  = 1'b1;
        card_lvl = 1'b1;
        tick(LAT + 4);
        chk("R8 no transfer after enable", NONE);
        host_lvl = 1'b1;
        settle();
        // disable in the middle of a transfer
        host_lvl = 1'b0;
        tick(LAT + 2);
        chk("R8 transfer under way", C_PD);
        line_en = 1'b0;
        tick(1);
        chk("R8 disable overrides hold", C_PD);
        host_lvl = 1'b1;
        tick(4);
        line_en = 1'b1;
        tick(1);
        chk("R8 no pull-up pulse after disable", NONE);
        tick(PU + 2);
        chk("R8 idle after re-enable", NONE);
    endtask

    initial begin
        t_reset();
        settle();
        t_host_master();
        t_card_master();
        t_slave_ignored();
        t_early_release();
        t_tie();
        t_disabled();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule